// File: doc/BRIEF.md
# Charge Command Watchdog Supervisor

This block supervises a host that programs a battery charger through register writes. It keeps the 16-bit charge-current command register and the 16-bit option register that carries a 2-bit timeout select. If the host fails to write a fresh charge command within the selected period, the block clears the charge-current command to zero, which suspends charging, and raises an expired flag. The flag stays up until the host restarts supervision.

Writes reach the block as already-decoded, single-cycle strobes carrying an address and a data word. There is no back-pressure: the block accepts every strobe in the cycle in which it is presented, so no ready signal exists. A prescaler turns the system clock into a one-second tick. Its length is a parameter, so a short run can use a small value. The three periods are parameters counted in ticks.

Top module: `chg_cmd_wdog`

## Requirements
- R1: During and after reset, with no writes, `ichg_q` is 0000h, `opt_q` is E70Eh (timeout select at bits 14:13 = 11), and `expired` is 0.
- R2: The timeout select `opt_q[14:13]` chooses the period: 01 gives 5 seconds, 10 gives 88 seconds, 11 gives 175 seconds, where one second is TICKS_PER_SEC clock cycles. Expiry happens on exactly the period-th clock edge after the restarting write's edge. On that edge `expired` rises and `ichg_q` becomes 0000h.
- R3: A write to address 14h loads `wr_data` into `ichg_q` and restarts the timer. A write to address 15h restarts the timer and leaves `ichg_q` unchanged. A restart clears `expired` on the write's edge.
- R4: A write to address 12h loads all 16 bits into `opt_q`. It restarts the timer only when the written bits 14:13 differ from the current select. A write that keeps bits 14:13 leaves the timer and `expired` untouched.
- R5: A write to any address other than 12h, 14h and 15h changes neither register nor the timer.
- R6: While the select is 00, the timer is stopped and cleared, `expired` is 0, and `ichg_q` is never cleared. Writing 00 clears an `expired` flag that is set.
- R7: After expiry, `expired` stays 1 and `ichg_q` stays 0000h until a restart. A restart starts a full new period.
- R8: A write to 14h on the same edge as expiry wins. `ichg_q` takes the written data, `expired` stays 0, and a new full period starts from that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| wr_valid | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 8 | Register address of the write |
| wr_data | input | 16 | Register data of the write |
| ichg_q | output | 16 | Charge-current command register |
| opt_q | output | 16 | Option register, timeout select at bits 14:13 |
| expired | output | 1 | Watchdog has expired and charging is suspended |

## Verification
The hardest case to reach is a charge-current write landing on the exact edge on which the timer would expire. The stimulus restarts the timer with a known write, counts period-minus-one falling edges, and then presents the next write so that it lands on the expiry edge. Another subtle case is an option write that changes other bits but keeps the select. The bench places it in the middle of a running period and after an expiry, and checks that the expiry edge and the flag do not move.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int SEL_LSB = 13;
  localparam int SEL_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_OPT  = 8'h12;
  localparam logic [ADDR_W-1:0] ADDR_ICHG = 8'h14;
  localparam logic [ADDR_W-1:0] ADDR_VCHG = 8'h15;

  localparam logic [DATA_W-1:0] OPT_RESET  = 16'hE70E;
  localparam logic [DATA_W-1:0] ICHG_RESET = 16'h0000;

  typedef enum logic [SEL_W-1:0] {
    SEL_OFF   = 2'b00,
    SEL_SHORT = 2'b01,
    SEL_MID   = 2'b10,
    SEL_LONG  = 2'b11
  } wdog_sel_e;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int TICKS_PER_SEC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic tick
);
  localparam int PW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICKS_PER_SEC - 1);

  logic [PW-1:0] pcnt;

  assign tick = run && !clr && (pcnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt <= '0;
    end else if (clr || !run || tick) begin
      pcnt <= '0;
    end else begin
      pcnt <= pcnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int SHORT_SEC = 5,
  parameter int MID_SEC   = 88,
  parameter int LONG_SEC  = 175
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             restart,
  input  logic             tick,
  output logic             run,
  output logic             expire_now,
  output logic             expired
);
  localparam int MAX_AB = (SHORT_SEC > MID_SEC) ? SHORT_SEC : MID_SEC;
  localparam int MAX_SEC = (MAX_AB > LONG_SEC) ? MAX_AB : LONG_SEC;
  localparam int SW = $clog2(MAX_SEC + 1);

  logic [SW-1:0] sec;
  logic [SW-1:0] last_sec;
  logic          enabled;

  always_comb begin
    case (wdog_sel_e'(sel))
      SEL_SHORT: last_sec = SW'(SHORT_SEC - 1);
      SEL_MID:   last_sec = SW'(MID_SEC - 1);
      SEL_LONG:  last_sec = SW'(LONG_SEC - 1);
      default:   last_sec = '0;
    endcase
  end

  assign enabled    = (wdog_sel_e'(sel) != SEL_OFF);
  assign run        = enabled && !expired;
  assign expire_now = run && !restart && tick && (sec == last_sec);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec     <= '0;
      expired <= 1'b0;
    end else if (restart || !enabled) begin
      sec     <= '0;
      expired <= 1'b0;
    end else if (expire_now) begin
      sec     <= '0;
      expired <= 1'b1;
    end else if (run && tick) begin
      sec <= sec + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              expire_now,
  output logic [DATA_W-1:0] ichg_q,
  output logic [DATA_W-1:0] opt_q,
  output logic              restart
);
  logic hit_opt, hit_ichg, hit_vchg, sel_change;

  assign hit_opt    = wr_valid && (wr_addr == ADDR_OPT);
  assign hit_ichg   = wr_valid && (wr_addr == ADDR_ICHG);
  assign hit_vchg   = wr_valid && (wr_addr == ADDR_VCHG);
  assign sel_change = hit_opt &&
                      (wr_data[SEL_LSB +: SEL_W] != opt_q[SEL_LSB +: SEL_W]);
  assign restart    = hit_ichg || hit_vchg || sel_change;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ichg_q <= ICHG_RESET;
    end else if (hit_ichg) begin
      ichg_q <= wr_data;
    end else if (expire_now) begin
      ichg_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opt_q <= OPT_RESET;
    end else if (hit_opt) begin
      opt_q <= wr_data;
    end
  end
endmodule

// File: rtl/chg_cmd_wdog.sv
module chg_cmd_wdog
  import wdog_pkg::*;
#(
  parameter int TICKS_PER_SEC = 125_000_000,
  parameter int SHORT_SEC     = 5,
  parameter int MID_SEC       = 88,
  parameter int LONG_SEC      = 175
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] ichg_q,
  output logic [DATA_W-1:0] opt_q,
  output logic              expired
);
  logic restart, tick, run, expire_now;

  wdog_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .expire_now (expire_now),
    .ichg_q     (ichg_q),
    .opt_q      (opt_q),
    .restart    (restart)
  );

  wdog_prescale #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .clr   (restart),
    .tick  (tick)
  );

  wdog_timer #(
    .SHORT_SEC (SHORT_SEC),
    .MID_SEC   (MID_SEC),
    .LONG_SEC  (LONG_SEC)
  ) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (opt_q[SEL_LSB +: SEL_W]),
    .restart    (restart),
    .tick       (tick),
    .run        (run),
    .expire_now (expire_now),
    .expired    (expired)
  );
endmodule

// File: rtl/chg_cmd_wdog_chk.sv
module chg_cmd_wdog_chk
  import wdog_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] ichg_q,
  input logic [DATA_W-1:0] opt_q,
  input logic              expired
);
  logic kick;
  assign kick = wr_valid && (wr_addr == ADDR_ICHG || wr_addr == ADDR_VCHG);

  // R6
  off_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opt_q[SEL_LSB +: SEL_W] == 2'b00) |-> !expired);

  // R2
  expire_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired) |-> (ichg_q == 16'h0000));

  // R3
  ichg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr == ADDR_ICHG) |=> (ichg_q == $past(wr_data)));

  // R8
  kick_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !expired);

  // R7
  flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !wr_valid) |=> (expired && ichg_q == 16'h0000));

  // R5
  foreign_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr != ADDR_OPT && wr_addr != ADDR_ICHG &&
     wr_addr != ADDR_VCHG && expired) |=> (expired && $stable(opt_q)));
endmodule

bind chg_cmd_wdog chg_cmd_wdog_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_valid (wr_valid),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .ichg_q   (ichg_q),
  .opt_q    (opt_q),
  .expired  (expired)
);

// File: tb/chg_cmd_wdog_tb_top.sv
module chg_cmd_wdog_tb_top;
  localparam int TPS = 4;
  localparam int NVEC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] ichg_q, opt_q;
  logic        expired;

  int checks = 0;
  int errors = 0;

  // each entry: {select code, charge-current value}
  localparam logic [17:0] VEC [NVEC] = '{
    {2'b01, 16'h1111}, {2'b10, 16'h2222}, {2'b11, 16'h3333}, {2'b01, 16'h0FFF}
  };

  chg_cmd_wdog #(.TICKS_PER_SEC(TPS)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .ichg_q(ichg_q), .opt_q(opt_q), .expired(expired)
  );

  always #4 clk = ~clk;

  function automatic int period_cycles(input logic [1:0] s);
    case (s)
      2'b01:   return 5 * TPS;
      2'b10:   return 88 * TPS;
      2'b11:   return 175 * TPS;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    wr_valid = 1'b1;
    wr_addr  = a;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
    wr_addr  = '0;
    wr_data  = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(3);
    chk("R1 ichg in reset", ichg_q, 16'h0000);
    chk("R1 opt in reset", opt_q, 16'hE70E);
    chk("R1 flag in reset", {15'b0, expired}, 16'h0000);
    rst_n = 1'b1;
    wait_cyc(10);
    chk("R1 ichg after reset", ichg_q, 16'h0000);
    chk("R1 flag after reset", {15'b0, expired}, 16'h0000);

    // R2 table: set select, restart by a charge-current write, time expiry
    for (int i = 0; i < NVEC; i++) begin
      logic [1:0]  s;
      logic [15:0] v;
      int          p;
      s = VEC[i][17:16];
      v = VEC[i][15:0];
      p = period_cycles(s);
      wr(8'h12, (16'hE70E & 16'h9FFF) | ({14'b0, s} << 13));
      wr(8'h14, v);
      chk("R3 ichg loaded", ichg_q, v);
      wait_cyc(p - 1);
      chk("R2 no flag one edge early", {15'b0, expired}, 16'h0000);
      chk("R2 ichg held one edge early", ichg_q, v);
      wait_cyc(1);
      chk("R2 flag at period", {15'b0, expired}, 16'h0001);
      chk("R2 ichg cleared at period", ichg_q, 16'h0000);
    end

    // now select 01 (opt A70E) and expired
    wr(8'h12, 16'hA70F);
    chk("R4 opt other bits loaded", opt_q, 16'hA70F);
    chk("R4 same select keeps flag", {15'b0, expired}, 16'h0001);
    wr(8'h20, 16'h5A5A);
    chk("R5 foreign addr keeps flag", {15'b0, expired}, 16'h0001);
    chk("R5 foreign addr keeps opt", opt_q, 16'hA70F);
    chk("R5 foreign addr keeps ichg", ichg_q, 16'h0000);
    wr(8'h12, 16'hC70F);
    chk("R4 select change clears flag", {15'b0, expired}, 16'h0000);
    wait_cyc(88 * TPS - 1);
    chk("R4 new period not yet over", {15'b0, expired}, 16'h0000);
    wait_cyc(1);
    chk("R4 new period expiry", {15'b0, expired}, 16'h0001);
    wait_cyc(50);
    chk("R7 flag stays", {15'b0, expired}, 16'h0001);
    chk("R7 ichg stays zero", ichg_q, 16'h0000);
    wr(8'h15, 16'h1234);
    chk("R3 voltage write clears flag", {15'b0, expired}, 16'h0000);
    chk("R3 voltage write keeps ichg", ichg_q, 16'h0000);
    wait_cyc(88 * TPS - 1);
    chk("R7 full new period", {15'b0, expired}, 16'h0001 ^ 16'h0001);
    wait_cyc(1);
    chk("R7 re-expiry", {15'b0, expired}, 16'h0001);

    // kick with voltage writes under select 01
    wr(8'h12, 16'hA70F);
    wr(8'h14, 16'h0ABC);
    for (int k = 0; k < 4; k++) begin
      wait_cyc(14);
      wr(8'h15, 16'h0000);
    end
    chk("R3 kicks prevent expiry", {15'b0, expired}, 16'h0000);
    chk("R3 kicks keep ichg", ichg_q, 16'h0ABC);

    // non-restarting writes mid-period
    wr(8'h14, 16'h0BCD);
    wait_cyc(5);
    wr(8'h20, 16'h0000);
    wr(8'h12, 16'hA70E);
    wait_cyc(12);
    chk("R5 expiry not moved, early", {15'b0, expired}, 16'h0000);
    wait_cyc(1);
    chk("R4 expiry not moved", {15'b0, expired}, 16'h0001);
    chk("R2 ichg cleared", ichg_q, 16'h0000);

    // disable
    wr(8'h12, 16'h870E);
    chk("R6 disable clears flag", {15'b0, expired}, 16'h0000);
    wr(8'h14, 16'h0555);
    wait_cyc(800);
    chk("R6 no expiry when off", {15'b0, expired}, 16'h0000);
    chk("R6 ichg kept when off", ichg_q, 16'h0555);
    wr(8'h12, 16'hA70E);
    wait_cyc(5 * TPS - 1);
    chk("R6 re-enable early", {15'b0, expired}, 16'h0000);
    wait_cyc(1);
    chk("R6 re-enable expiry", {15'b0, expired}, 16'h0001);

    // same-edge write at expiry
    wr(8'h14, 16'h0111);
    wait_cyc(5 * TPS - 1);
    wr(8'h14, 16'h0222);
    chk("R8 write wins ichg", ichg_q, 16'h0222);
    chk("R8 write wins flag", {15'b0, expired}, 16'h0000);
    wait_cyc(5 * TPS - 1);
    chk("R8 new period early", {15'b0, expired}, 16'h0000);
    wait_cyc(1);
    chk("R8 new period expiry", {15'b0, expired}, 16'h0001);
    chk("R8 ichg cleared later", ichg_q, 16'h0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule